// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

An 8-bit timer/counter with one compare channel and a single waveform output pin. Software reaches it through a small register window: a counter register, a compare register, a control register, a clock-source register, an interrupt flag register and an interrupt mask register. A clock-select stage turns either the bus clock or a slow external timer clock into a count enable, through a prescaler with seven divide ratios or a stop setting. The external timer clock passes through a synchroniser and an edge detector. Every event and every status flag it produces is therefore raised in the bus clock domain.

Four counting modes share one counter. A free-running up count overflows at 0xFF. A clear-on-match mode gives a variable-frequency square wave. A single-slope PWM mode counts up and wraps. A dual-slope PWM mode counts up to 0xFF and back down to 0. The compare register has two copies. Software writes the buffered copy, and the comparator reads the active copy. In the PWM modes the active copy is loaded only at a turning point of the count, so a new duty value never cuts a pulse short. Overflow and compare-match events set sticky flags. Each flag is masked separately onto its own interrupt line.

Top module: `tmr8_wavetimer`

## Requirements
- R1: After reset the counter, both compare copies, all control fields, the flags and the masks are zero, and irq_ovf, irq_cmp and wave_o are low.
- R2: The clock code is CTRL[2:0]. Code 000 stops the counter, which then holds its value however long it waits.
- R3: The clock codes 001 to 111 give one count per 1, 8, 32, 64, 128, 256 and 1024 source clocks, in that order.
- R4: When SRC[0] is 1, the source clock is the rising edges of tmr_clk_ext, and the bus clock alone advances nothing. Each rising edge adds one count (code 001) after a latency of a few bus clocks. The external clock must run slower than half the bus clock.
- R5: The mode is CTRL[4:3]. In the free-running mode (00) the count rises by one per tick and wraps from 0xFF to 0. That wrap sets the overflow flag FLAGS[0].
- R6: A tick on which the counter equals the active compare copy sets the compare flag FLAGS[1].
- R7: In clear-on-match mode (01) a match tick loads 0 into the counter, so the period is compare+1 ticks. With output action CTRL[6:5]=01 the output toggles on each match. Action 00 holds the output low.
- R8: In single-slope PWM (10) with action 10, the output goes high on the 0xFF-to-0 wrap and low on a match. The wrap wins on a tie, so the output is high for compare+1 of every 256 ticks. Action 11 inverts this.
- R9: In dual-slope PWM (11) the count runs 1..0xFF up and 0xFE..0 down, a period of 510 ticks. It turns down at 0xFF, and it turns up at 0, where it sets FLAGS[0]. With action 10 an upward match drives the output low and a downward match drives it high.
- R10: In the PWM modes a compare write reaches the active copy only on the tick at 0xFF. In the other two modes it takes effect at once. A read of the compare address returns the buffered copy.
- R11: Writing 1 to a bit of FLAGS clears that flag, and so does its acknowledge input. A new event in the same cycle wins over either clear.
- R12: irq_ovf is FLAGS[0] AND MASK[0], and irq_cmp is FLAGS[1] AND MASK[1].
- R13: A counter write loads the written value on that clock edge, taking priority over a tick in the same cycle.

Register addresses: 0 counter, 1 compare, 2 control, 3 clock source, 4 flags, 5 mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tmr_clk_ext | input | 1 | Slow external timer clock, asynchronous to clk |
| ack_ovf | input | 1 | Overflow interrupt acknowledge, clears FLAGS[0] |
| ack_cmp | input | 1 | Compare interrupt acknowledge, clears FLAGS[1] |
| irq_ovf | output | 1 | Masked overflow interrupt request |
| irq_cmp | output | 1 | Masked compare interrupt request |
| wave_o | output | 1 | Waveform output pin |

## Verification
The bench targets the corner cases where a plausible design goes wrong. The first is a compare value of 0xFF in single-slope PWM: if the tie between wrap and match is resolved the wrong way, the output pulses low once per period instead of staying high. The second is a compare write issued mid-period in PWM mode. A design that loads the active copy at once would set the compare flag at the new value in the same period, when the old value should still match. The third is the dual-slope turn at 0xFF and the 510-tick duty count: an off-by-one at either turning point changes the measured high time. The fourth is a flag acknowledge in the same cycle as an overflow event: a design that lets the clear win loses the interrupt.

// File: rtl/tmr8_pkg.sv
// Shared types and register map for the eight-bit waveform timer.
// Assumes an 8-bit register window with three address bits.
package tmr8_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_FAST   = 2'd2,
        MODE_PHASE  = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } tmr_act_e;

    // Per-tick events produced by the count unit
    typedef struct packed {
        logic ovf;       // overflow / bottom turnaround
        logic match;     // counter equalled the active compare copy
        logic restart;   // single-slope wrap from top to zero
        logic going_up;  // count direction at the time of the tick
    } tmr_evt_t;

    localparam int          REG_AW      = 3;
    localparam logic [2:0]  RA_COUNT    = 3'd0;
    localparam logic [2:0]  RA_COMPARE  = 3'd1;
    localparam logic [2:0]  RA_CONTROL  = 3'd2;
    localparam logic [2:0]  RA_SOURCE   = 3'd3;
    localparam logic [2:0]  RA_FLAGS    = 3'd4;
    localparam logic [2:0]  RA_MASK     = 3'd5;

    localparam int          NUM_FLAGS   = 2;
    localparam int          FLAG_OVF    = 0;
    localparam int          FLAG_CMP    = 1;

    // True for the two modes whose compare copy is buffered
    function automatic logic is_pwm(input tmr_mode_e m);
        return (m == MODE_FAST) || (m == MODE_PHASE);
    endfunction

endpackage

// File: rtl/tmr8_clksel.sv
// Clock-select stage: turns either the bus clock or the synchronised
// rising edges of a slow external clock into a one-cycle count enable,
// divided by a prescaler picked by a three-bit code (0 = stopped).
// Assumes PSC_W >= 10 and an external clock slower than clk/2.
module tmr8_clksel
    import tmr8_pkg::*;
#(
    parameter int PSC_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       async_sel,
    input  logic [2:0] clk_code,
    input  logic       ext_clk,
    output logic       tick_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [PSC_W-1:0]       psc_q;
    logic                   src_edge;
    logic [PSC_W-1:0]       tap;

    // Prescaler tap mask: a tick falls where the masked bits are all ones
    function automatic logic [PSC_W-1:0] tap_mask(input logic [2:0] code);
        case (code)
            3'd2:    return PSC_W'(10'd7);
            3'd3:    return PSC_W'(10'd31);
            3'd4:    return PSC_W'(10'd63);
            3'd5:    return PSC_W'(10'd127);
            3'd6:    return PSC_W'(10'd255);
            3'd7:    return PSC_W'(10'd1023);
            default: return '0;
        endcase
    endfunction

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            // Shift the external clock through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            end
        end else begin : g_single
            // Single-stage capture when only one stage is configured
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_clk;
            end
        end
    endgenerate

    // Remember the last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // Source edge: every bus clock, or one synchronised rising edge
    assign src_edge = async_sel ? (sync_q[LAST] & ~prev_q) : 1'b1;
    assign tap      = tap_mask(clk_code);

    // Free-running prescaler counts source edges
    always_ff @(posedge clk) begin
        if (!rst_n)        psc_q <= '0;
        else if (src_edge) psc_q <= psc_q + PSC_W'(1);
    end

    // Emit a tick when the selected prescaler bits are all ones
    assign tick_o = (clk_code != 3'd0) && src_edge && ((psc_q & tap) == tap);

    // Divide-by-8 in bus-clock mode never gives back-to-back ticks
    assert_psc_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && clk_code == 3'd2 && !async_sel)
        |=> (!tick_o || clk_code != 3'd2 || async_sel));

endmodule

// File: rtl/tmr8_count.sv
// Count unit: the counter, its direction, the double-buffered compare
// register and the per-tick event decode for all four modes.
// Assumes tick is a one-cycle enable in the clk domain.
module tmr8_count
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_buf_o,
    output tmr_evt_t         evt_o
);

    localparam logic [CNT_W-1:0] TOP_V = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] buf_q, act_q;
    logic             dir_q, dir_d;
    logic             at_top, at_bot, equal, upd;

    assign at_top = (cnt_q == TOP_V);
    assign at_bot = (cnt_q == '0);
    assign equal  = (cnt_q == act_q);

    // Next count, direction and events for the selected mode
    always_comb begin
        cnt_d         = cnt_q;
        dir_d         = (mode == MODE_PHASE) ? dir_q : 1'b1;
        upd           = 1'b0;
        evt_o.ovf     = 1'b0;
        evt_o.restart = 1'b0;
        evt_o.match   = tick && equal;
        evt_o.going_up = dir_q;
        if (tick) begin
            case (mode)
                MODE_NORMAL: begin
                    cnt_d     = cnt_q + ONE;
                    evt_o.ovf = at_top;
                end
                MODE_CTC: begin
                    cnt_d     = equal ? '0 : cnt_q + ONE;
                    evt_o.ovf = at_top && !equal;
                end
                MODE_FAST: begin
                    cnt_d         = cnt_q + ONE;
                    evt_o.ovf     = at_top;
                    evt_o.restart = at_top;
                    upd           = at_top;
                end
                default: begin
                    if (dir_q) begin
                        if (at_top) begin
                            dir_d = 1'b0;
                            cnt_d = TOP_V - ONE;
                            upd   = 1'b1;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end else begin
                        if (at_bot) begin
                            dir_d     = 1'b1;
                            cnt_d     = ONE;
                            evt_o.ovf = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
            endcase
        end
        if (cnt_wr) cnt_d = cnt_wdata;
    end

    // Counter and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    // Compare buffer: software-facing copy
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_q <= '0;
        else if (cmp_wr) buf_q <= cmp_wdata;
    end

    // Active compare copy: direct in non-PWM modes, loaded at top in PWM
    always_ff @(posedge clk) begin
        if (!rst_n)              act_q <= '0;
        else if (!is_pwm(mode))  act_q <= cmp_wr ? cmp_wdata : buf_q;
        else if (upd)            act_q <= buf_q;
    end

    assign cnt_o     = cnt_q;
    assign cmp_buf_o = buf_q;

    // With no tick and no write the count holds
    assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    // In PWM modes the active copy only moves at the update point
    assert_dbuf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(mode) && !upd) |=> $stable(act_q));

    // Clear-on-match reloads zero after the matching tick
    assert_ctc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CTC && tick && equal && !cnt_wr) |=> (cnt_q == '0));

    // Dual-slope count turns downward at the top
    assert_phase_turn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PHASE && tick && dir_q && at_top && !cnt_wr)
        |=> (!dir_q && cnt_q == TOP_V - ONE));

endmodule

// File: rtl/tmr8_wave.sv
// Waveform generator: keeps the output latch and applies the output
// action for the current mode on compare, wrap and match events.
// Assumes events are already qualified by the count enable.
module tmr8_wave
    import tmr8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tmr_mode_e mode,
    input  tmr_act_e  act,
    input  tmr_evt_t  evt,
    output logic      wave_o
);

    logic out_q, out_d, pin_en;

    // Output latch next-state per mode and action
    always_comb begin
        out_d = out_q;
        if (act == ACT_OFF) begin
            out_d = 1'b0;
        end else begin
            case (mode)
                MODE_NORMAL, MODE_CTC: begin
                    if (evt.match) begin
                        case (act)
                            ACT_TOGGLE: out_d = ~out_q;
                            ACT_CLEAR:  out_d = 1'b0;
                            default:    out_d = 1'b1;
                        endcase
                    end
                end
                MODE_FAST: begin
                    if (act == ACT_CLEAR) begin
                        if (evt.restart)    out_d = 1'b1;
                        else if (evt.match) out_d = 1'b0;
                    end else if (act == ACT_SET) begin
                        if (evt.restart)    out_d = 1'b0;
                        else if (evt.match) out_d = 1'b1;
                    end
                end
                default: begin
                    if (evt.match && act == ACT_CLEAR)
                        out_d = !evt.going_up;
                    else if (evt.match && act == ACT_SET)
                        out_d = evt.going_up;
                end
            endcase
        end
    end

    // Output latch register
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    // Toggle has no meaning in PWM modes: the pin stays low there
    assign pin_en = (act != ACT_OFF) && !(is_pwm(mode) && act == ACT_TOGGLE);
    assign wave_o = out_q && pin_en;

    // Single-slope wrap always leaves the non-inverted output high
    assert_fast_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAST && act == ACT_CLEAR && evt.restart) |=> out_q);

endmodule

// File: rtl/tmr8_wavetimer.sv
// Top of the eight-bit waveform timer: register window, sticky flags
// with masks, and the clock-select, count and waveform units.
// Assumes one write per cycle and CNT_W of at least 8.
module tmr8_wavetimer
    import tmr8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              tmr_clk_ext,
    input  logic              ack_ovf,
    input  logic              ack_cmp,
    output logic              irq_ovf,
    output logic              irq_cmp,
    output logic              wave_o
);

    logic [6:0]           ctrl_q;
    logic                 src_q;
    logic [NUM_FLAGS-1:0] mask_q, flag_q, evt_vec, ack_vec, w1c_vec;
    logic                 wr_cnt, wr_cmp, wr_ctrl, wr_src, wr_flags, wr_mask;
    logic                 tick;
    logic [CNT_W-1:0]     cnt_w, cmp_buf_w;
    tmr_mode_e            mode_w;
    tmr_act_e             act_w;
    tmr_evt_t             evt_w;

    assign wr_cnt   = bus_wr && (bus_addr == RA_COUNT);
    assign wr_cmp   = bus_wr && (bus_addr == RA_COMPARE);
    assign wr_ctrl  = bus_wr && (bus_addr == RA_CONTROL);
    assign wr_src   = bus_wr && (bus_addr == RA_SOURCE);
    assign wr_flags = bus_wr && (bus_addr == RA_FLAGS);
    assign wr_mask  = bus_wr && (bus_addr == RA_MASK);

    // Control, clock-source and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            src_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[6:0];
            if (wr_src)  src_q  <= bus_wdata[0];
            if (wr_mask) mask_q <= bus_wdata[NUM_FLAGS-1:0];
        end
    end

    assign mode_w = tmr_mode_e'(ctrl_q[4:3]);
    assign act_w  = tmr_act_e'(ctrl_q[6:5]);

    tmr8_clksel #(
        .PSC_W       (PSC_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clksel (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_sel (src_q),
        .clk_code  (ctrl_q[2:0]),
        .ext_clk   (tmr_clk_ext),
        .tick_o    (tick)
    );

    tmr8_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode_w),
        .cnt_wr    (wr_cnt),
        .cnt_wdata (bus_wdata),
        .cmp_wr    (wr_cmp),
        .cmp_wdata (bus_wdata),
        .cnt_o     (cnt_w),
        .cmp_buf_o (cmp_buf_w),
        .evt_o     (evt_w)
    );

    tmr8_wave u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_w),
        .act    (act_w),
        .evt    (evt_w),
        .wave_o (wave_o)
    );

    assign evt_vec = {evt_w.match, evt_w.ovf};
    assign ack_vec = {ack_cmp, ack_ovf};
    assign w1c_vec = wr_flags ? bus_wdata[NUM_FLAGS-1:0] : '0;

    generate
        for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
            logic fq;
            // Sticky flag: event sets, write-one or acknowledge clears
            always_ff @(posedge clk) begin
                if (!rst_n)          fq <= 1'b0;
                else if (evt_vec[f]) fq <= 1'b1;
                else if (w1c_vec[f] || ack_vec[f]) fq <= 1'b0;
            end
            assign flag_q[f] = fq;
        end
    endgenerate

    assign irq_ovf = flag_q[FLAG_OVF] & mask_q[FLAG_OVF];
    assign irq_cmp = flag_q[FLAG_CMP] & mask_q[FLAG_CMP];

    // Register read multiplexer
    always_comb begin
        case (bus_addr)
            RA_COUNT:   bus_rdata = cnt_w;
            RA_COMPARE: bus_rdata = cmp_buf_w;
            RA_CONTROL: bus_rdata = CNT_W'(ctrl_q);
            RA_SOURCE:  bus_rdata = CNT_W'(src_q);
            RA_FLAGS:   bus_rdata = CNT_W'(flag_q);
            RA_MASK:    bus_rdata = CNT_W'(mask_q);
            default:    bus_rdata = '0;
        endcase
    end

    // An overflow event is always visible in the flag next cycle
    assert_ovf_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_w.ovf |=> flag_q[FLAG_OVF]);

    // A compare match is always visible in the flag next cycle
    assert_cmp_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_w.match |=> flag_q[FLAG_CMP]);

    // Acknowledge without a competing event clears the flag
    assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ovf && !evt_w.ovf) |=> !flag_q[FLAG_OVF]);

endmodule

// File: tb/tmr8_wavetimer_tb.sv
`timescale 1ns/1ps
module tmr8_wavetimer_tb;

    localparam int A_CNT = 0, A_CMP = 1, A_CTRL = 2, A_SRC = 3, A_FLG = 4, A_MSK = 5;
    localparam int M_NORM = 0, M_CTC = 1, M_FAST = 2, M_PHASE = 3;
    localparam int X_OFF = 0, X_TOG = 1, X_CLR = 2, X_SET = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tmr_clk_ext = 1'b0;
    logic       ack_ovf = 1'b0;
    logic       ack_cmp = 1'b0;
    logic       irq_ovf, irq_cmp, wave_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr8_wavetimer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tmr_clk_ext (tmr_clk_ext),
        .ack_ovf     (ack_ovf),
        .ack_cmp     (ack_cmp),
        .irq_ovf     (irq_ovf),
        .irq_cmp     (irq_cmp),
        .wave_o      (wave_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ctl(input int act, input int mode, input int cs);
        return (act << 5) | (mode << 3) | cs;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr  = 3'(a);
        bus_wdata = 8'(d);
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 3'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic prep(input int c, input int m);
        wr(A_CTRL, 0);
        wr(A_CNT, c);
        wr(A_CMP, m);
        wr(A_FLG, 3);
    endtask

    // Count high samples of wave_o over n consecutive cycles
    task automatic duty(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (wave_o) hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int v;
        for (int a = 0; a < 6; a++) begin
            rd(a, v);
            chk("R1", $sformatf("register %0d after reset", a), v, 0);
        end
        chk("R1", "irq_ovf after reset", int'(irq_ovf), 0);
        chk("R1", "irq_cmp after reset", int'(irq_cmp), 0);
        chk("R1", "wave_o after reset", int'(wave_o), 0);
    endtask

    task automatic t_stop_and_load;
        int v, held;
        prep(8'h20, 8'h00);
        wr(A_CTRL, ctl(X_OFF, M_NORM, 1));
        run(5);
        wr(A_CNT, 8'h77);                  // R13: load beats the tick
        rd(A_CNT, v);
        chk("R13", "count after load", v, 8'h77);
        run(1);
        rd(A_CNT, v);
        chk("R13", "count one tick after load", v, 8'h78);
        wr(A_CTRL, 0);                     // R2: code 000 stops
        rd(A_CNT, held);
        run(50);
        rd(A_CNT, v);
        chk("R2", "count held while stopped", v, held);
    endtask

    task automatic t_prescale;
        int v;
        prep(0, 8'hF0);
        wr(A_CTRL, ctl(X_OFF, M_NORM, 2));
        run(80);
        rd(A_CNT, v);
        chk("R3", "divide by 8 over 80 clocks", v, 10);
        prep(0, 8'hF0);
        wr(A_CTRL, ctl(X_OFF, M_NORM, 7));
        run(2048);
        rd(A_CNT, v);
        chk("R3", "divide by 1024 over 2048 clocks", v, 2);
        wr(A_CTRL, 0);
    endtask

    task automatic t_async;
        int v;
        prep(0, 8'hF0);
        wr(A_SRC, 1);
        wr(A_CTRL, ctl(X_OFF, M_NORM, 1));
        run(20);
        rd(A_CNT, v);
        chk("R4", "bus clock alone does not count", v, 0);
        for (int p = 0; p < 5; p++) begin
            tmr_clk_ext = 1'b1;
            repeat (4) @(negedge clk);
            tmr_clk_ext = 1'b0;
            repeat (4) @(negedge clk);
        end
        run(6);
        rd(A_CNT, v);
        chk("R4", "five external edges", v, 5);
        wr(A_CTRL, 0);
        wr(A_SRC, 0);
    endtask

    task automatic t_overflow;
        int v;
        prep(8'hFD, 8'h10);
        wr(A_CTRL, ctl(X_OFF, M_NORM, 1));
        run(2);
        rd(A_FLG, v);
        chk("R5", "no overflow at 0xFF yet", v & 1, 0);
        run(1);
        rd(A_CNT, v);
        chk("R5", "count wrapped to zero", v, 0);
        rd(A_FLG, v);
        chk("R5", "overflow flag after wrap", v & 1, 1);
        wr(A_CTRL, 0);
    endtask

    task automatic t_ctc;
        int v;
        prep(0, 5);
        wr(A_CTRL, ctl(X_TOG, M_CTC, 1));
        chk("R7", "output low before first match", int'(wave_o), 0);
        run(5);
        rd(A_CNT, v);
        chk("R7", "count reaches compare", v, 5);
        chk("R7", "output still low", int'(wave_o), 0);
        run(1);
        rd(A_CNT, v);
        chk("R7", "count cleared after match", v, 0);
        chk("R7", "output toggled high", int'(wave_o), 1);
        rd(A_FLG, v);
        chk("R6", "compare flag on match", (v >> 1) & 1, 1);
        run(6);
        chk("R7", "output toggled low after one period", int'(wave_o), 0);
        rd(A_FLG, v);
        chk("R7", "no overflow in short period", v & 1, 0);
        wr(A_CTRL, 0);
        chk("R7", "action off holds output low", int'(wave_o), 0);
    endtask

    task automatic t_fast;
        int hi;
        prep(0, 8'h40);
        wr(A_CTRL, ctl(X_CLR, M_FAST, 1));
        run(300);
        duty(256, hi);
        chk("R8", "duty with compare 0x40", hi, 65);
        wr(A_CMP, 8'hFF);
        run(300);
        duty(256, hi);
        chk("R8", "duty with compare 0xFF stays high", hi, 256);
        wr(A_CMP, 8'h40);
        wr(A_CTRL, ctl(X_SET, M_FAST, 1));
        run(300);
        duty(256, hi);
        chk("R8", "inverted duty with compare 0x40", hi, 191);
        wr(A_CTRL, 0);
    endtask

    task automatic t_dbuf;
        int v;
        prep(8'h10, 8'h20);
        wr(A_CTRL, ctl(X_OFF, M_NORM, 1));
        run(16);
        rd(A_FLG, v);
        chk("R10", "no match before new value", (v >> 1) & 1, 0);
        run(1);
        rd(A_FLG, v);
        chk("R10", "non-PWM write took effect at once", (v >> 1) & 1, 1);
        prep(8'h10, 8'h40);
        wr(A_CTRL, ctl(X_CLR, M_FAST, 0));
        wr(A_CMP, 8'h80);
        rd(A_CMP, v);
        chk("R10", "compare read returns buffer", v, 8'h80);
        wr(A_CTRL, ctl(X_CLR, M_FAST, 1));
        run(8'h30);
        rd(A_FLG, v);
        chk("R10", "no match before old value", (v >> 1) & 1, 0);
        run(1);
        rd(A_FLG, v);
        chk("R10", "old active value still matches", (v >> 1) & 1, 1);
        rd(A_CNT, v);
        chk("R10", "count just past old value", v, 8'h41);
        wr(A_FLG, 2);
        run(256);
        rd(A_FLG, v);
        chk("R10", "old value no longer matches after top", (v >> 1) & 1, 0);
        run(8'h40);
        rd(A_FLG, v);
        chk("R10", "new value matches after top", (v >> 1) & 1, 1);
        wr(A_CTRL, 0);
    endtask

    task automatic t_phase;
        int v, hi;
        prep(8'hFE, 8'h40);
        wr(A_CTRL, ctl(X_CLR, M_PHASE, 1));
        run(1);
        rd(A_CNT, v);
        chk("R9", "count rises to top", v, 8'hFF);
        run(1);
        rd(A_CNT, v);
        chk("R9", "count turns down at top", v, 8'hFE);
        prep(0, 8'h40);
        wr(A_CTRL, ctl(X_CLR, M_PHASE, 1));
        run(600);
        duty(510, hi);
        chk("R9", "dual-slope high time for 0x40", hi, 128);
        rd(A_FLG, v);
        chk("R9", "overflow set at bottom turn", v & 1, 1);
        wr(A_CTRL, 0);
    endtask

    task automatic t_flags;
        int v;
        prep(8'hFF, 8'h10);
        wr(A_MSK, 1);
        wr(A_CTRL, ctl(X_OFF, M_NORM, 1));
        ack_ovf = 1'b1;                    // acknowledge on the event edge
        @(posedge clk);
        @(negedge clk);
        ack_ovf = 1'b0;
        rd(A_FLG, v);
        chk("R11", "event wins over acknowledge", v & 1, 1);
        chk("R12", "irq_ovf with mask set", int'(irq_ovf), 1);
        wr(A_MSK, 0);
        chk("R12", "irq_ovf masked off", int'(irq_ovf), 0);
        @(negedge clk);
        ack_ovf = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_ovf = 1'b0;
        rd(A_FLG, v);
        chk("R11", "acknowledge clears overflow flag", v & 1, 0);
        run(40);
        rd(A_FLG, v);
        chk("R6", "compare flag after passing 0x10", (v >> 1) & 1, 1);
        chk("R12", "irq_cmp masked off", int'(irq_cmp), 0);
        wr(A_MSK, 2);
        chk("R12", "irq_cmp with mask set", int'(irq_cmp), 1);
        wr(A_FLG, 2);
        rd(A_FLG, v);
        chk("R11", "write one clears compare flag", (v >> 1) & 1, 0);
        chk("R12", "irq_cmp drops with flag", int'(irq_cmp), 0);
        wr(A_CTRL, 0);
        wr(A_MSK, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop_and_load();
        t_prescale();
        t_async();
        t_overflow();
        t_ctc();
        t_fast();
        t_dbuf();
        t_phase();
        t_flags();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (R1..): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule